// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit logical address into a 21-bit physical address. The logical space of 64 KB is cut into eight windows of 8 KB. The top three logical bits pick one of eight 8-bit page registers. That register becomes the upper part of the physical address, and the 13 offset bits pass straight through. The result is a 2 MB physical reach from a 64 KB logical view.

Software, or a sequencer, loads the page registers through a small access port. Each write carries a data byte and an 8-bit select mask, so one write can load several page registers at the same time. A read uses the same mask to choose which register to show. The translation side takes a logical address with a valid strobe and returns the physical address, registered, one cycle later.

Top module: `page_xlate_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first write, every page register holds its preset value (all 0x00 by default). The last-written byte is 0x00, `xl_pvalid` is 0 and `xl_paddr` is 0.
- R2: Physical bits [12:0] of a translation equal logical bits [12:0] of the request.
- R3: Physical bits [20:13] equal page register k, where k = logical bits [15:13]. So register 0 serves 0x0000–0x1FFF and register 7 serves 0xE000–0xFFFF.
- R4: `xl_pvalid` in a cycle equals `xl_valid` of the cycle before. The matching `xl_paddr` appears in that same cycle, one cycle after the request.
- R5: When `xl_valid` is 0, `xl_paddr` keeps its previous value in the next cycle.
- R6: On a write (`reg_we`=1), every page register i with `reg_mask[i]`=1 takes `reg_wdata` at that clock edge. Registers whose mask bit is 0 keep their value.
- R7: A write with `reg_mask`=0 changes no page register. Every write, whatever its mask, records `reg_wdata` as the last-written byte.
- R8: `reg_rdata` is combinational. It shows page register i, where i is the lowest set bit of `reg_mask`.
- R9: With `reg_mask`=0, `reg_rdata` shows the last-written byte.
- R10: A translation requested in the same cycle as a write to its page register uses the value from before the write. The next translation uses the new value.
- R11: During a write cycle, `reg_rdata` shows the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Page register write strobe |
| reg_mask | input | 8 | Page register select mask, bit i selects register i |
| reg_wdata | input | 8 | Byte to be written |
| reg_rdata | output | 8 | Register read value, chosen by the mask |
| xl_valid | input | 1 | Translation request strobe |
| xl_laddr | input | 16 | Logical address |
| xl_pvalid | output | 1 | Translation result valid, one cycle after the request |
| xl_paddr | output | 21 | Physical address |

## Verification
The assertions assume that every input carries a known 0 or 1 value from reset release onward. They also assume that inputs change only away from the rising clock edge, because each property compares the registered outputs with the inputs sampled one edge earlier. The bench drives all inputs to zero during reset and changes them only on falling edges. It then waits for the two-stage reset release before it issues any write or translation.

// File: rtl/xl_pkg.sv
`timescale 1ns/1ps
package xl_pkg;
  // source of the value shown on the register read port
  typedef enum logic {
    RD_PAGE = 1'b0,
    RD_LAST = 1'b1
  } rd_src_e;
endpackage

// File: rtl/xl_rst_sync.sv
`timescale 1ns/1ps
module xl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/xl_page_file.sv
`timescale 1ns/1ps
module xl_page_file #(
  parameter int NPG  = 8,
  parameter int PN_W = 8,
  parameter logic [NPG*PN_W-1:0] PRESET = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [NPG-1:0]            mask,
  input  logic [PN_W-1:0]           wdata,
  output logic [NPG-1:0][PN_W-1:0]  pages,
  output logic [PN_W-1:0]           last_wr
);
  logic [NPG-1:0][PN_W-1:0] pg_q;
  logic [NPG-1:0][PN_W-1:0] pg_d;
  logic [NPG-1:0]           pg_en;
  logic [PN_W-1:0]          last_q;
  logic [PN_W-1:0]          last_d;

  genvar g;
  generate
    for (g = 0; g < NPG; g++) begin : g_pg
      always_comb begin
        pg_en[g] = we & mask[g];
        pg_d[g]  = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pg_q[g] <= PRESET[g*PN_W +: PN_W];
        else if (pg_en[g])  pg_q[g] <= pg_d[g];
      end
    end
  endgenerate

  always_comb begin
    last_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_q <= '0;
    else if (we)  last_q <= last_d;
  end

  assign pages   = pg_q;
  assign last_wr = last_q;
endmodule

// File: rtl/xl_read_sel.sv
`timescale 1ns/1ps
module xl_read_sel
  import xl_pkg::*;
#(
  parameter int NPG  = 8,
  parameter int PN_W = 8
) (
  input  logic [NPG-1:0]            mask,
  input  logic [NPG-1:0][PN_W-1:0]  pages,
  input  logic [PN_W-1:0]           last_wr,
  output logic [PN_W-1:0]           rdata
);
  rd_src_e         src;
  logic [PN_W-1:0] pick;

  // scan from the top down so the lowest set bit is the one that sticks
  always_comb begin
    pick = '0;
    src  = RD_LAST;
    for (int i = NPG-1; i >= 0; i--) begin
      if (mask[i]) begin
        pick = pages[i];
        src  = RD_PAGE;
      end
    end
  end

  always_comb begin
    unique case (src)
      RD_PAGE: rdata = pick;
      RD_LAST: rdata = last_wr;
    endcase
  end
endmodule

// File: rtl/xl_translate.sv
`timescale 1ns/1ps
module xl_translate #(
  parameter int LA_W    = 16,
  parameter int PG_BITS = 3,
  parameter int PN_W    = 8,
  localparam int NPG    = 1 << PG_BITS,
  localparam int OFF_W  = LA_W - PG_BITS,
  localparam int PA_W   = OFF_W + PN_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid,
  input  logic [LA_W-1:0]           laddr,
  input  logic [NPG-1:0][PN_W-1:0]  pages,
  output logic                      pvalid,
  output logic [PA_W-1:0]           paddr
);
  logic [PG_BITS-1:0] idx;
  logic [PA_W-1:0]    pa_d;
  logic [PA_W-1:0]    pa_q;
  logic               pv_q;

  always_comb begin
    idx  = laddr[LA_W-1 -: PG_BITS];
    pa_d = {pages[idx], laddr[OFF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pa_q <= '0;
    else if (valid) pa_q <= pa_d;
  end

  assign pvalid = pv_q;
  assign paddr  = pa_q;
endmodule

// File: rtl/page_xlate_unit.sv
`timescale 1ns/1ps
module page_xlate_unit #(
  parameter int LA_W    = 16,
  parameter int PG_BITS = 3,
  parameter int PN_W    = 8,
  parameter logic [(PN_W<<PG_BITS)-1:0] PAGE_PRESET = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_we,
  input  logic [(1<<PG_BITS)-1:0]          reg_mask,
  input  logic [PN_W-1:0]                  reg_wdata,
  output logic [PN_W-1:0]                  reg_rdata,
  input  logic                             xl_valid,
  input  logic [LA_W-1:0]                  xl_laddr,
  output logic                             xl_pvalid,
  output logic [LA_W-PG_BITS+PN_W-1:0]     xl_paddr
);
  localparam int NPG = 1 << PG_BITS;

  logic                     rst_q_n;
  logic [NPG-1:0][PN_W-1:0] pages_w;
  logic [PN_W-1:0]          last_w;

  xl_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  xl_page_file #(.NPG(NPG), .PN_W(PN_W), .PRESET(PAGE_PRESET)) u_file (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .we      (reg_we),
    .mask    (reg_mask),
    .wdata   (reg_wdata),
    .pages   (pages_w),
    .last_wr (last_w)
  );

  xl_read_sel #(.NPG(NPG), .PN_W(PN_W)) u_rd (
    .mask    (reg_mask),
    .pages   (pages_w),
    .last_wr (last_w),
    .rdata   (reg_rdata)
  );

  xl_translate #(.LA_W(LA_W), .PG_BITS(PG_BITS), .PN_W(PN_W)) u_xl (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .valid  (xl_valid),
    .laddr  (xl_laddr),
    .pages  (pages_w),
    .pvalid (xl_pvalid),
    .paddr  (xl_paddr)
  );
endmodule

// File: rtl/page_xlate_chk.sv
`timescale 1ns/1ps
module page_xlate_chk #(
  parameter int LA_W    = 16,
  parameter int PG_BITS = 3,
  parameter int PN_W    = 8,
  localparam int NPG    = 1 << PG_BITS,
  localparam int OFF_W  = LA_W - PG_BITS,
  localparam int PA_W   = OFF_W + PN_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [NPG-1:0]            reg_mask,
  input  logic [PN_W-1:0]           reg_wdata,
  input  logic [PN_W-1:0]           reg_rdata,
  input  logic                      xl_valid,
  input  logic [LA_W-1:0]           xl_laddr,
  input  logic                      xl_pvalid,
  input  logic [PA_W-1:0]           xl_paddr,
  input  logic [NPG-1:0][PN_W-1:0]  pages
);
  logic [PN_W-1:0] sel_pn;
  assign sel_pn = pages[xl_laddr[LA_W-1 -: PG_BITS]];

  // R4
  pvalid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_pvalid == $past(xl_valid));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> xl_paddr[OFF_W-1:0] == $past(xl_laddr[OFF_W-1:0]));

  // R3
  page_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> xl_paddr[PA_W-1:OFF_W] == $past(sel_pn));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |=> $stable(xl_paddr));

  // R9
  last_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_mask != '0) || (reg_rdata == $past(reg_wdata)));

  // R8
  low_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_mask[0] |-> reg_rdata == pages[0]);

  genvar g;
  generate
    for (g = 0; g < NPG; g++) begin : g_pg
      // R6
      mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_mask[g]) |=> pages[g] == $past(reg_wdata));
      // R7
      unsel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_mask[g]) |=> $stable(pages[g]));
    end
  endgenerate
endmodule

bind page_xlate_unit page_xlate_chk #(
  .LA_W(LA_W), .PG_BITS(PG_BITS), .PN_W(PN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .reg_we    (reg_we),
  .reg_mask  (reg_mask),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .xl_valid  (xl_valid),
  .xl_laddr  (xl_laddr),
  .xl_pvalid (xl_pvalid),
  .xl_paddr  (xl_paddr),
  .pages     (pages_w)
);

// File: tb/sim_page_xlate_unit.sv
`timescale 1ns/1ps
module sim_page_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_mask;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        xl_valid;
  logic [15:0] xl_laddr;
  logic        xl_pvalid;
  logic [20:0] xl_paddr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] mdl [8];
  logic [7:0] mlast;

  always #2.5 clk = ~clk;

  page_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_mask(reg_mask),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_valid(xl_valid),
    .xl_laddr(xl_laddr), .xl_pvalid(xl_pvalid), .xl_paddr(xl_paddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return mdl[i];
    return mlast;
  endfunction

  function automatic logic [20:0] exp_pa(input logic [15:0] la);
    return {mdl[la[15:13]], la[12:0]};
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] m, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_mask = m; reg_wdata = d;
    cyc();
    for (int i = 0; i < 8; i++) if (m[i]) mdl[i] = d;
    mlast = d;
    @(negedge clk);
    reg_we = 1'b0; reg_mask = 8'h00;
  endtask

  task automatic xl(input logic [15:0] la, input string req);
    logic [20:0] e;
    @(negedge clk);
    xl_valid = 1'b1; xl_laddr = la;
    e = exp_pa(la);
    cyc();
    chk({req, " pvalid"}, {31'd0, xl_pvalid}, 32'd1);
    chk({req, " paddr"}, {11'd0, xl_paddr}, {11'd0, e});
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_mask = 8'h00; reg_wdata = 8'h00;
    xl_valid = 1'b0; xl_laddr = 16'h0000;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mlast = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;

    // R1: reset state at the ports
    chk("R1 pvalid", {31'd0, xl_pvalid}, 32'd0);
    chk("R1 paddr", {11'd0, xl_paddr}, 32'd0);
    chk("R1 last", {24'd0, reg_rdata}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      reg_mask = 8'h01 << i; #1;
      chk("R1 page", {24'd0, reg_rdata}, 32'd0);
    end
    reg_mask = 8'h00;

    // R6, R8: load each page alone and read it back with a one-hot mask
    for (int i = 0; i < 8; i++) wr(8'h01 << i, 8'h11 * i[7:0] + 8'h07);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); reg_mask = 8'h01 << i; #1;
      chk("R6 single load", {24'd0, reg_rdata}, {24'd0, mdl[i]});
    end

    // R6: one write loads several pages, others stay
    wr(8'hA5, 8'h3C);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); reg_mask = 8'h01 << i; #1;
      chk("R6 multi load", {24'd0, reg_rdata}, {24'd0, mdl[i]});
    end

    // R7, R9: mask zero write leaves pages, updates last byte
    wr(8'h00, 8'h9E);
    @(negedge clk); reg_mask = 8'h00; #1;
    chk("R9 last byte", {24'd0, reg_rdata}, 32'h9E);
    for (int i = 0; i < 8; i++) begin
      reg_mask = 8'h01 << i; #1;
      chk("R7 untouched", {24'd0, reg_rdata}, {24'd0, mdl[i]});
    end

    // R8: every mask value, lowest set bit wins
    for (int m = 0; m < 256; m++) begin
      @(negedge clk); reg_mask = m[7:0]; #1;
      chk("R8 mask sweep", {24'd0, reg_rdata}, {24'd0, exp_rd(m[7:0])});
    end
    reg_mask = 8'h00;

    // give each page a distinct value
    for (int i = 0; i < 8; i++) wr(8'h01 << i, 8'hC0 ^ (8'h1D * i[7:0]));

    // R2, R3, R4: every page with several offsets, back to back
    for (int p = 0; p < 8; p++) begin
      xl({p[2:0], 13'h0000}, "R3 page base");
      xl({p[2:0], 13'h0001}, "R2 offset one");
      xl({p[2:0], 13'h1555}, "R2 offset pattern");
      xl({p[2:0], 13'h1FFF}, "R3 page top");
    end

    // R5: idle holds the last address
    @(negedge clk); xl_valid = 1'b0; xl_laddr = 16'h4321;
    cyc();
    chk("R5 pvalid low", {31'd0, xl_pvalid}, 32'd0);
    chk("R5 hold", {11'd0, xl_paddr}, {11'd0, exp_pa(16'hFFFF)});
    cyc();
    chk("R5 hold again", {11'd0, xl_paddr}, {11'd0, exp_pa(16'hFFFF)});

    // R10, R11: write and translate to the same page in one cycle
    begin
      logic [20:0] old_pa;
      old_pa = exp_pa(16'h6ABC);
      @(negedge clk);
      reg_we = 1'b1; reg_mask = 8'h08; reg_wdata = 8'h5A;
      xl_valid = 1'b1; xl_laddr = 16'h6ABC; #1;
      chk("R11 read during write", {24'd0, reg_rdata}, {24'd0, mdl[3]});
      cyc();
      mdl[3] = 8'h5A; mlast = 8'h5A;
      chk("R10 old value", {11'd0, xl_paddr}, {11'd0, old_pa});
      @(negedge clk); reg_we = 1'b0; reg_mask = 8'h00;
      cyc();
      chk("R10 new value", {11'd0, xl_paddr}, {11'd0, exp_pa(16'h6ABC)});
    end
    @(negedge clk); xl_valid = 1'b0;
    cyc();
    chk("R4 pvalid drop", {31'd0, xl_pvalid}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule